// File: doc/BRIEF.md
# UART Receive Buffer Status Controller

This block sits between a UART receive front end and a simple register bus. When the front end reports a completed frame, the block captures the byte into a one-entry buffer. It keeps a sticky set of flags for that reception: data ready, overrun, noise, framing error, idle frame and break frame. It also implements the read side effects that clear those flags, and it drives a DMA request and a receive interrupt line.

If a frame completes while the buffer still holds unread data, the stored byte is preserved, the new byte is dropped, and the overrun flag is raised. The error and line-condition flags clear only through a two-step sequence: a status read followed by a data read. Any frame arriving between the two steps cancels the sequence, so a status read taken before an error appeared can never clear that error.

Register reads are combinational on the address: the read data always shows the addressed register, and the side effects come only from the read strobe.

Top module: `rx_buffer_status`

## Requirements
- R1: A frame-done strobe while data-ready is clear loads the byte into the buffer. It sets data-ready in the next cycle, and in that same cycle it ORs the frame's framing, noise, idle and break indications into their sticky flags.
- R2: A data read clears data-ready. A data read is a bus read with address 1, or a DMA acknowledge. A bus write to address 0 with write-data bit 0 equal to 0 also clears data-ready. A status write with bit 0 equal to 1 changes nothing, and a write to address 1 changes nothing.
- R3: A frame-done strobe while data-ready is set, with no data read in the same cycle, sets the overrun flag. The buffer keeps its old byte, and the new byte and its indications are discarded.
- R4: A frame-done strobe in the same cycle as a data read is accepted as in R1 and does not set overrun.
- R5: A bus read of address 0, followed later by a data read, clears the overrun, noise, framing, idle and break flags, provided no frame arrives in between. A data read without an earlier status read leaves those flags unchanged.
- R6: A frame-done strobe cancels a pending status read. A data read after such a frame therefore leaves every error flag set.
- R7: The read data at address 0 is the status word: bit0 data-ready, bit1 overrun, bit2 noise, bit3 framing, bit4 idle, bit5 break, and the upper bits are 0. At address 1 the read data is the buffered byte.
- R8: The DMA request is high exactly while DMA mode is on and data-ready is set.
- R9: When DMA mode is off, data-ready with the ready-interrupt enable raises the interrupt. A framing error reaches the interrupt through the data-ready flag that is set with it.
- R10: The overrun flag raises the interrupt when either the ready-interrupt enable is set, or both the error-interrupt enable and DMA mode are set.
- R11: When DMA mode is on, the framing or noise flag raises the interrupt only when the error-interrupt enable is set. Data-ready alone raises no interrupt in DMA mode.
- R12: After reset, all flags are 0, the buffer is 0, and the DMA request and interrupt are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| frameDone | input | 1 | Front end completed a frame |
| frameByte | input | DATA_W | Received byte |
| frameFerr | input | 1 | Frame had a framing error |
| frameNoise | input | 1 | Frame had noise |
| frameIdle | input | 1 | Frame was an idle frame |
| frameBreak | input | 1 | Frame was a break frame |
| busRd | input | 1 | Bus read strobe |
| busWr | input | 1 | Bus write strobe |
| busAddr | input | 1 | 0 = status, 1 = data |
| busWdata | input | RD_W | Bus write data |
| busRdata | output | RD_W | Read data for the addressed register |
| dmaMode | input | 1 | DMA receive mode enable |
| dmaAck | input | 1 | DMA has read the data register |
| dmaReq | output | 1 | DMA request |
| ieRdy | input | 1 | Data-ready interrupt enable |
| ieErr | input | 1 | Error interrupt enable |
| irq | output | 1 | Receive interrupt |

## Verification
The hardest state to reach is a cancelled clear sequence. It needs a status read, then a frame arrival, then a data read, with an error already set before the status read. The bench builds this order with explicit single-cycle operations and confirms that the flags survive. The two races, a frame in the same cycle as a data read and overrun in DMA mode, are driven as single combined cycles. A behavioural model is compared with every output on each clock.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  localparam int ST_RDY   = 0;
  localparam int ST_OVR   = 1;
  localparam int ST_NOISE = 2;
  localparam int ST_FERR  = 3;
  localparam int ST_IDLE  = 4;
  localparam int ST_BRK   = 5;
  localparam int ST_W     = 6;

  typedef struct packed {
    logic loadBuf;
    logic clrRdy;
    logic setOvr;
    logic clrErr;
  } rxsStrobe_t;
endpackage

// File: rtl/rxs_ctrl.sv
module rxs_ctrl
  import rxs_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             frameDone,
  input  logic             busRd,
  input  logic             busWr,
  input  logic             busAddr,
  input  logic             wrBit0,
  input  logic             dmaAck,
  input  logic [ST_W-1:0]  status,
  output rxsStrobe_t       strobe
);
  logic armed;
  logic dataRd, statRd, statClr, accept;

  assign dataRd  = (busRd && busAddr) || dmaAck;
  assign statRd  = busRd && !busAddr;
  assign statClr = busWr && !busAddr && !wrBit0;
  assign accept  = frameDone && (!status[ST_RDY] || dataRd);

  always_comb begin
    strobe.loadBuf = accept;
    strobe.clrRdy  = (dataRd || statClr) && !accept;
    strobe.setOvr  = frameDone && status[ST_RDY] && !dataRd;
    strobe.clrErr  = armed && dataRd && !frameDone;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)          armed <= 1'b0;
    else if (frameDone) armed <= 1'b0;
    else if (statRd)    armed <= 1'b1;
    else if (dataRd)    armed <= 1'b0;
  end

  p_accept_sets_rdy_r1: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && !status[ST_RDY]) |=> status[ST_RDY]);

  p_read_clears_rdy_r2: assert property (@(posedge clk) disable iff (!rstN)
    (dataRd && !frameDone) |=> !status[ST_RDY]);

  p_overrun_flag_r3: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && status[ST_RDY] && !dataRd) |=> status[ST_OVR]);

  p_err_survives_frame_r6: assert property (@(posedge clk) disable iff (!rstN)
    (frameDone && (status[ST_OVR] || status[ST_FERR] || status[ST_NOISE]))
      |=> (status[ST_OVR] || status[ST_FERR] || status[ST_NOISE]));
endmodule

// File: rtl/rxs_datapath.sv
module rxs_datapath
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  rxsStrobe_t        strobe,
  input  logic [DATA_W-1:0] frameByte,
  input  logic              frameFerr,
  input  logic              frameNoise,
  input  logic              frameIdle,
  input  logic              frameBreak,
  output logic [DATA_W-1:0] bufData,
  output logic [ST_W-1:0]   status
);
  logic rdyQ, ovrQ, noiseQ, ferrQ, idleQ, brkQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bufData <= '0;
      rdyQ    <= 1'b0;
      ovrQ    <= 1'b0;
      noiseQ  <= 1'b0;
      ferrQ   <= 1'b0;
      idleQ   <= 1'b0;
      brkQ    <= 1'b0;
    end else begin
      if (strobe.clrErr) begin
        ovrQ   <= 1'b0;
        noiseQ <= 1'b0;
        ferrQ  <= 1'b0;
        idleQ  <= 1'b0;
        brkQ   <= 1'b0;
      end
      if (strobe.setOvr) ovrQ <= 1'b1;
      if (strobe.clrRdy) rdyQ <= 1'b0;
      if (strobe.loadBuf) begin
        bufData <= frameByte;
        rdyQ    <= 1'b1;
        ferrQ   <= ferrQ  | frameFerr;
        noiseQ  <= noiseQ | frameNoise;
        idleQ   <= idleQ  | frameIdle;
        brkQ    <= brkQ   | frameBreak;
      end
    end
  end

  always_comb begin
    status          = '0;
    status[ST_RDY]  = rdyQ;
    status[ST_OVR]  = ovrQ;
    status[ST_NOISE]= noiseQ;
    status[ST_FERR] = ferrQ;
    status[ST_IDLE] = idleQ;
    status[ST_BRK]  = brkQ;
  end

  p_overrun_keeps_byte_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobe.setOvr |=> $stable(bufData));
endmodule

// File: rtl/rx_buffer_status.sv
module rx_buffer_status
  import rxs_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int RD_W = (DATA_W > ST_W) ? DATA_W : 8
)(
  input  logic              clk,
  input  logic              rstN,
  input  logic              frameDone,
  input  logic [DATA_W-1:0] frameByte,
  input  logic              frameFerr,
  input  logic              frameNoise,
  input  logic              frameIdle,
  input  logic              frameBreak,
  input  logic              busRd,
  input  logic              busWr,
  input  logic              busAddr,
  input  logic [RD_W-1:0]   busWdata,
  output logic [RD_W-1:0]   busRdata,
  input  logic              dmaMode,
  input  logic              dmaAck,
  output logic              dmaReq,
  input  logic              ieRdy,
  input  logic              ieErr,
  output logic              irq
);
  rxsStrobe_t        strobe;
  logic [ST_W-1:0]   status;
  logic [DATA_W-1:0] bufData;
  logic              errAny;

  rxs_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .busRd(busRd),
    .busWr(busWr), .busAddr(busAddr), .wrBit0(busWdata[0]),
    .dmaAck(dmaAck), .status(status), .strobe(strobe)
  );

  rxs_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .frameByte(frameByte),
    .frameFerr(frameFerr), .frameNoise(frameNoise), .frameIdle(frameIdle),
    .frameBreak(frameBreak), .bufData(bufData), .status(status)
  );

  always_comb begin
    busRdata = '0;
    if (busAddr) busRdata[DATA_W-1:0] = bufData;
    else         busRdata[ST_W-1:0]   = status;
  end

  assign errAny = status[ST_FERR] || status[ST_NOISE] || status[ST_OVR];
  assign dmaReq = dmaMode && status[ST_RDY];
  assign irq = (ieRdy && status[ST_RDY] && !dmaMode)
            || (status[ST_OVR] && (ieRdy || (ieErr && dmaMode)))
            || (dmaMode && ieErr && errAny);

  p_irq_ready_r9: assert property (@(posedge clk) disable iff (!rstN)
    (!dmaMode && ieRdy && status[ST_RDY]) |-> irq);

  p_dma_quiet_r11: assert property (@(posedge clk) disable iff (!rstN)
    (dmaMode && !ieErr && !ieRdy) |-> !irq);
endmodule

// File: tb/sim_rx_buffer_status.sv
`timescale 1ns/1ps
module sim_rx_buffer_status;
  localparam int DW = 8;
  localparam int RW = 8;

  logic clk = 0, rstN = 0;
  logic frameDone = 0, frameFerr = 0, frameNoise = 0, frameIdle = 0, frameBreak = 0;
  logic [DW-1:0] frameByte = '0;
  logic busRd = 0, busWr = 0, busAddr = 0;
  logic [RW-1:0] busWdata = '0;
  logic [RW-1:0] busRdata;
  logic dmaMode = 0, dmaAck = 0, dmaReq, ieRdy = 0, ieErr = 0, irq;

  int checks = 0, failures = 0;
  bit done = 0, started = 0;

  // behavioural reference state
  logic [7:0] mBuf;
  bit mRdy, mOvr, mNe, mFe, mId, mBk, mArm;

  always #2 clk = ~clk;

  rx_buffer_status #(.DATA_W(DW)) u0 (
    .clk(clk), .rstN(rstN), .frameDone(frameDone), .frameByte(frameByte),
    .frameFerr(frameFerr), .frameNoise(frameNoise), .frameIdle(frameIdle),
    .frameBreak(frameBreak), .busRd(busRd), .busWr(busWr), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .dmaMode(dmaMode),
    .dmaAck(dmaAck), .dmaReq(dmaReq), .ieRdy(ieRdy), .ieErr(ieErr), .irq(irq)
  );

  function automatic logic [7:0] mStatus();
    return {2'b00, mBk, mId, mFe, mNe, mOvr, mRdy};
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mBuf = 0; {mRdy, mOvr, mNe, mFe, mId, mBk, mArm} = '0;
    end else begin
      bit rd, wasArm;
      rd = (busRd && busAddr) || dmaAck;
      wasArm = mArm;
      if (frameDone) mArm = 0;
      else if (busRd && !busAddr) mArm = 1;
      else if (rd) mArm = 0;
      if (wasArm && rd && !frameDone) {mOvr, mNe, mFe, mId, mBk} = '0;
      if (frameDone && mRdy && !rd) mOvr = 1;
      else if (frameDone) begin
        mBuf = frameByte; mRdy = 1;
        mFe |= frameFerr; mNe |= frameNoise; mId |= frameIdle; mBk |= frameBreak;
      end else if (rd || (busWr && !busAddr && !busWdata[0])) mRdy = 0;
    end
  end

  task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // compare every cycle against the model
  always @(negedge clk) if (started && rstN) begin
    bit eIrq;
    eIrq = (ieRdy && mRdy && !dmaMode) || (mOvr && (ieRdy || (ieErr && dmaMode)))
        || (dmaMode && ieErr && (mFe || mNe || mOvr));
    check("R7 rdata model", busRdata, busAddr ? mBuf : mStatus());
    check("R8 dmaReq model", {7'd0, dmaReq}, {7'd0, dmaMode && mRdy});
    check("R9/R10/R11 irq model", {7'd0, irq}, {7'd0, eIrq});
  end

  task automatic cyc(bit fd, logic [7:0] b, bit fe, bit ne, bit id, bit bk,
                     bit rd, bit wr, bit a, logic [7:0] wd, bit ack);
    @(negedge clk); #1;
    frameDone = fd; frameByte = b; frameFerr = fe; frameNoise = ne;
    frameIdle = id; frameBreak = bk; busRd = rd; busWr = wr; busAddr = a;
    busWdata = wd; dmaAck = ack;
    @(negedge clk); #1;
    {frameDone, frameFerr, frameNoise, frameIdle, frameBreak, busRd, busWr, dmaAck} = '0;
  endtask

  task automatic frame(logic [7:0] b, bit fe, bit ne, bit id, bit bk);
    cyc(1, b, fe, ne, id, bk, 0, 0, 0, 0, 0);
  endtask
  task automatic rdStat(); cyc(0, 0, 0, 0, 0, 0, 1, 0, 0, 0, 0); endtask
  task automatic rdData(); cyc(0, 0, 0, 0, 0, 0, 1, 0, 1, 0, 0); endtask
  task automatic ack();    cyc(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 1); endtask
  task automatic wrStat(logic [7:0] v); cyc(0, 0, 0, 0, 0, 0, 0, 1, 0, v, 0); endtask

  task automatic peek(bit a, logic [7:0] exp, string tag);
    busAddr = a; #1;
    check(tag, busRdata, exp);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1;
    started = 1;
    @(negedge clk); #1;
    peek(0, 8'h00, "R12 status after reset");
    peek(1, 8'h00, "R12 buffer after reset");
    check("R12 irq after reset", {7'd0, irq}, 8'd0);
    check("R12 dmaReq after reset", {7'd0, dmaReq}, 8'd0);

    ieRdy = 1;
    frame(8'hA5, 0, 0, 0, 0);
    peek(0, 8'h01, "R1 ready set");
    peek(1, 8'hA5, "R1 byte captured");
    check("R9 irq on ready", {7'd0, irq}, 8'd1);

    frame(8'h3C, 1, 1, 0, 0);
    peek(0, 8'h03, "R3 overrun, new flags dropped");
    peek(1, 8'hA5, "R3 old byte kept");

    rdData();
    peek(0, 8'h02, "R5 data read alone keeps overrun");
    check("R10 irq from overrun", {7'd0, irq}, 8'd1);

    rdStat();
    frame(8'h77, 1, 0, 0, 0);
    peek(0, 8'h0B, "R9 framing with ready");
    rdData();
    peek(0, 8'h0A, "R6 cancelled sequence keeps errors");

    rdStat();
    rdData();
    peek(0, 8'h00, "R5 sequence clears all");

    frame(8'h11, 0, 1, 1, 1);
    peek(0, 8'h35, "R7 noise idle break layout");
    cyc(1, 8'h22, 0, 0, 0, 0, 1, 0, 1, 0, 0);
    peek(0, 8'h35, "R4 same-cycle read, no overrun");
    peek(1, 8'h22, "R4 new byte accepted");

    wrStat(8'h01);
    peek(0, 8'h35, "R2 write bit0=1 ignored");
    cyc(0, 0, 0, 0, 0, 0, 0, 1, 1, 8'h00, 0);
    peek(0, 8'h35, "R2 data write ignored");
    wrStat(8'h00);
    peek(0, 8'h34, "R2 write 0 clears ready");
    rdStat(); rdData();
    peek(0, 8'h00, "R5 cleared again");

    ieRdy = 0; dmaMode = 1;
    frame(8'h5A, 0, 0, 0, 0);
    #1 check("R8 dma request", {7'd0, dmaReq}, 8'd1);
    check("R11 no irq on ready in dma", {7'd0, irq}, 8'd0);
    ack();
    #1 check("R8 request dropped on ack", {7'd0, dmaReq}, 8'd0);
    peek(0, 8'h00, "R2 ack clears ready");

    frame(8'h66, 1, 0, 0, 0);
    #1 check("R11 framing masked in dma", {7'd0, irq}, 8'd0);
    ieErr = 1; #1;
    check("R11 framing irq with ieErr", {7'd0, irq}, 8'd1);
    frame(8'h67, 0, 0, 0, 0);
    rdStat(); ack();
    peek(0, 8'h00, "R5 cleared via ack");

    frame(8'h01, 0, 0, 0, 0);
    frame(8'h02, 0, 0, 0, 0);
    #1 check("R10 overrun irq via ieErr+dma", {7'd0, irq}, 8'd1);
    ieErr = 0; ieRdy = 1; #1;
    check("R10 overrun irq via ieRdy", {7'd0, irq}, 8'd1);
    ieRdy = 0; #1;
    check("R10 overrun masked", {7'd0, irq}, 8'd0);

    repeat (4) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule